// File: doc/BRIEF.md
# Gated shift clock generator

This block derives two divided clocks from a dot clock for a display output stage. The reference clock runs all the time. The shift clock has the same ratio and phase, but it is held low while the active-low system blank input is asserted. Both outputs are registered pulse trains. A pulse is one dot-clock cycle high, repeated once every N dot cycles. With N = 1 the output is high every cycle.

A split-transfer flag can request a shift pulse early, during blank. The first synchronised rising edge of the flag in a blank interval fires one shift pulse at once. The first normal shift pulse after blank ends is then dropped, so the frame still receives the same number of shift pulses. Blank and the flag are both synchronised to the dot clock inside the block. The divider keeps counting through blank, so the shift clock never drifts away from the reference clock.

Top module: `shift_clk_gen`

## Requirements
- R1: While `rst` is high, both `shift_clk` and `ref_clk` are low, and the divider, early-use state and drop state are cleared.
- R2: `div_sel` codes 0, 1, 2, 3 and 4 select the ratios N = 1, 2, 4, 8 and 16. `ref_clk` is high for exactly one dot cycle in every N cycles, and is high every cycle when N = 1.
- R3: `div_sel` codes 5, 6 and 7 behave as ratio 1.
- R4: `ref_clk` has the same pulse count whether `blank_n` is 0 or 1.
- R5: While the synchronised `blank_n` is 0, normal shift pulses are blocked. A change on `blank_n` reaches `shift_clk` after three dot-clock edges: two synchroniser stages and the output register.
- R6: Outside blank, every `shift_clk` pulse falls in the same cycle as a `ref_clk` pulse.
- R7: A 0-to-1 change of `split_flag` while blank is active gives one `shift_clk` pulse that lasts one cycle. The pulse is visible in the cycle after the third rising dot-clock edge that follows the change.
- R8: Only the first flag rise in a blank interval fires a pulse. Later rises in the same interval give no shift pulse.
- R9: After an early pulse has fired, the first normal shift pulse after blank is dropped, and the normal pulses after it pass.
- R10: When no early pulse fired during blank, no pulse is dropped after blank. A flag rise outside blank has no effect on `shift_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| blank_n | input | 1 | System blank, active low, asynchronous to clk |
| split_flag | input | 1 | Split-transfer flag, asynchronous to clk |
| div_sel | input | 3 | Divide-ratio select code |
| shift_clk | output | 1 | Blank-gated shift clock pulses |
| ref_clk | output | 1 | Free-running reference clock pulses |

## Verification
Two functions can fall in the same cycle. The first divider tick after blank lifts can be both a tick that must be dropped and the tick that clears the drop state. A flag rise can also land on a reference tick inside blank. The bench provokes the first case by releasing blank in the cycle of a visible reference pulse at ratio 16, so that the next tick falls well after the synchroniser has settled. It then judges shift and reference pulse counts over a fixed 64-cycle window: the shift count must be one lower than the reference count only when an early pulse fired. An embedded property also checks that the drop state clears only on a tick outside blank.

// File: rtl/scg_pkg.sv
package scg_pkg;
  // Map a select code to log2 of the divide ratio; codes above max fall back to 0 (ratio 1).
  function automatic int ratio_log2(input int sel, input int max_log2);
    if (sel <= max_log2) return sel;
    return 0;
  endfunction
endpackage

// File: rtl/scg_sync.sv
module scg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scg_divider.sv
module scg_divider
  import scg_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int MAX_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick,
  output logic             ref_q
);
  localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  int               lg;

  always_comb begin
    lg   = ratio_log2(int'(div_sel), MAX_LOG2);
    lim  = CNT_W'((1 << lg) - 1);
    tick = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ref_q <= 1'b0;
    end else begin
      cnt   <= (cnt >= lim) ? '0 : cnt + 1'b1;
      ref_q <= tick;
    end
  end

  // R2
  ref_single_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && lim != '0 && $stable(div_sel)) |=> !tick);
endmodule

// File: rtl/scg_gate.sv
module scg_gate (
  input  logic clk,
  input  logic rst,
  input  logic in_blank,
  input  logic flag_s,
  input  logic tick,
  output logic shift_q
);
  logic flag_d;
  logic early_used;
  logic drop_next;
  logic flag_rise;
  logic early_fire;
  logic normal;

  always_comb begin
    flag_rise  = flag_s & ~flag_d;
    early_fire = in_blank & flag_rise & ~early_used;
    normal     = tick & ~in_blank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_d     <= 1'b0;
      early_used <= 1'b0;
      drop_next  <= 1'b0;
      shift_q    <= 1'b0;
    end else begin
      flag_d  <= flag_s;
      shift_q <= early_fire | (normal & ~drop_next);
      if (!in_blank)       early_used <= 1'b0;
      else if (early_fire) early_used <= 1'b1;
      if (early_fire)      drop_next  <= 1'b1;
      else if (normal)     drop_next  <= 1'b0;
    end
  end

  // R5
  blank_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (in_blank && !early_fire) |=> !shift_q);

  // R8
  one_early_chk: assert property (@(posedge clk) disable iff (rst)
    (early_used && in_blank) |=> !(shift_q && !$past(tick)));

  // R9
  drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(drop_next) && !$past(rst)) |-> ($past(tick) && !$past(in_blank)));
endmodule

// File: rtl/shift_clk_gen.sv
module shift_clk_gen #(
  parameter int SEL_W       = 3,
  parameter int MAX_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blank_n,
  input  logic             split_flag,
  input  logic [SEL_W-1:0] div_sel,
  output logic             shift_clk,
  output logic             ref_clk
);
  logic [1:0] sync_in;
  logic [1:0] sync_out;
  logic       tick;
  logic       ref_q;
  logic       shift_q;

  assign sync_in = {blank_n, split_flag};

  scg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_in),
    .q   (sync_out)
  );

  scg_divider #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_div (
    .clk     (clk),
    .rst     (rst),
    .div_sel (div_sel),
    .tick    (tick),
    .ref_q   (ref_q)
  );

  scg_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .in_blank (~sync_out[1]),
    .flag_s   (sync_out[0]),
    .tick     (tick),
    .shift_q  (shift_q)
  );

  assign shift_clk = shift_q;
  assign ref_clk   = ref_q;

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (!shift_clk && !ref_clk));

  // R6
  shift_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_clk && !ref_clk) |-> $past(~sync_out[1]));
endmodule

// File: tb/shift_clk_gen_bench.sv
module shift_clk_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       blank_n = 1'b0;
  logic       split_flag = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       shift_clk;
  logic       ref_clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  shift_clk_gen u_shift_clk_gen (
    .clk        (clk),
    .rst        (rst),
    .blank_n    (blank_n),
    .split_flag (split_flag),
    .div_sel    (div_sel),
    .shift_clk  (shift_clk),
    .ref_clk    (ref_clk)
  );

  // {sel[2:0], blank_n, ref pulses in 64, shift pulses in 64}
  localparam logic [19:0] VEC [10] = '{
    {3'd0, 1'b1, 8'd64, 8'd64},  // R2
    {3'd1, 1'b1, 8'd32, 8'd32},  // R2
    {3'd2, 1'b1, 8'd16, 8'd16},  // R2
    {3'd3, 1'b1, 8'd8,  8'd8 },  // R2
    {3'd4, 1'b1, 8'd4,  8'd4 },  // R2
    {3'd5, 1'b1, 8'd64, 8'd64},  // R3
    {3'd7, 1'b1, 8'd64, 8'd64},  // R3
    {3'd2, 1'b0, 8'd16, 8'd0 },  // R4 R5
    {3'd4, 1'b0, 8'd4,  8'd0 },  // R4 R5
    {3'd0, 1'b0, 8'd64, 8'd0 }   // R4 R5
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_win(input int n, output int r, output int s, output int mis);
    r = 0; s = 0; mis = 0;
    repeat (n) begin
      @(negedge clk);
      r += int'(ref_clk);
      s += int'(shift_clk);
      if (shift_clk && !ref_clk) mis++;
    end
  endtask

  task automatic wait_ref;
    do @(negedge clk); while (!ref_clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r, s, mis;
    // R1: outputs low during reset
    repeat (4) @(negedge clk);
    check("R1 shift in reset", int'(shift_clk), 0);
    check("R1 ref in reset", int'(ref_clk), 0);
    rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      div_sel = VEC[i][19:17];
      blank_n = VEC[i][16];
      repeat (40) @(negedge clk);
      count_win(64, r, s, mis);
      check($sformatf("R2/R3/R4 ref vec%0d", i), r, int'(VEC[i][15:8]));
      check($sformatf("R5/R6 shift vec%0d", i), s, int'(VEC[i][7:0]));
    end

    // R7: early pulse latency and width (blank already low, ratio 16)
    div_sel = 3'd4;
    blank_n = 1'b0;
    repeat (40) @(negedge clk);
    split_flag = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 early pulse", int'(shift_clk), 1);
    @(negedge clk);
    check("R7 pulse width", int'(shift_clk), 0);

    // R8: second rise in same blank ignored
    split_flag = 1'b0;
    repeat (5) @(negedge clk);
    split_flag = 1'b1;
    count_win(12, r, s, mis);
    check("R8 second rise", s, 0);
    split_flag = 1'b0;
    repeat (10) @(negedge clk);

    // R9: release blank aligned to a ref pulse; first normal pulse dropped
    wait_ref();
    blank_n = 1'b1;
    count_win(64, r, s, mis);
    check("R9 ref count", r, 4);
    check("R9 shift count", s, 3);
    check("R6 phase", mis, 0);

    // R10: blank interval with no flag rise drops nothing
    blank_n = 1'b0;
    repeat (40) @(negedge clk);
    wait_ref();
    blank_n = 1'b1;
    count_win(64, r, s, mis);
    check("R10 no drop", s, 4);

    // R10: flag rise outside blank has no effect
    split_flag = 1'b1;
    repeat (3) @(negedge clk);
    split_flag = 1'b0;
    repeat (3) @(negedge clk);
    split_flag = 1'b1;
    count_win(64, r, s, mis);
    check("R10 flag outside blank shift", s, 4);
    check("R10 flag outside blank phase", mis, 0);
    split_flag = 1'b0;

    // R5: gating latency of three edges
    wait_ref();
    repeat (10) @(negedge clk);
    blank_n = 1'b0;
    wait_ref();
    check("R5 gated after sync", int'(shift_clk), 0);

    // R1: reset mid-run clears outputs and the pending drop state
    blank_n = 1'b0;
    repeat (20) @(negedge clk);
    split_flag = 1'b1;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 shift mid reset", int'(shift_clk), 0);
    check("R1 ref mid reset", int'(ref_clk), 0);
    rst = 1'b0;
    split_flag = 1'b0;
    blank_n = 1'b1;
    repeat (20) @(negedge clk);
    count_win(64, r, s, mis);
    check("R1 no drop after reset", s, 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule